// File: doc/BRIEF.md
# Planar Video Memory Read Formatter

This block stands between a processor-side read port and a four-plane video memory that belongs to a display controller. The processor never drives the memory bus itself. It posts a read request with an address. The block then holds that request on the memory side until the display fetch logic grants a stolen slot. In that slot it samples the four plane bytes at the address and forms one result byte from them.

A format register chooses how the byte is built. In single-plane mode the byte is the data of the chosen plane. In color-search mode each bit of the byte reports whether that pixel's plane bits equal a programmed color. The display mode sets which planes exist for the processor. In four-plane mode every plane is visible. In two-plane mode only one pair of planes is reachable, and a frame bit picks the lower pair or the upper pair. This lets software reach the pair that is not on screen while the display keeps running.

Top module: `vrf_read_formatter`

## Requirements
- R1: After reset, busy, rd_valid and vram_req are 0 and rd_data is 0x00.
- R2: A rd_req seen while idle sets busy from the next cycle. vram_req equals busy, and vram_addr presents the captured rd_addr while busy.
- R3: The cycle after a cycle with busy and steal_grant both high, rd_valid is 1 for exactly one cycle and busy is 0. rd_data keeps that result until the next rd_valid.
- R4: A rd_req raised while busy is ignored: vram_addr does not change and no extra rd_valid pulse follows.
- R5: fmt_wdata layout is bit 9 search mode, bit 8 frame B, bits 7:4 plane select (bit 4 is logical plane 0), and bits 3:0 color (bit 0 is logical plane 0). A fmt_we pulse loads it, and the next read uses it.
- R6: In single-plane mode (bit 9 = 0) with display mode four-plane (disp_mode = 0) and one select bit set, rd_data is that plane's byte. Physical plane p lies in vram_rdata[8p+7:8p].
- R7: In four-plane display mode the frame bit has no effect on the result.
- R8: In color-search mode, bit k of rd_data is 1 when, for every participating logical plane i, bit k of that plane equals color bit i. A plane participates if its select bit is set and the display mode uses it.
- R9: In two-plane display mode (disp_mode = 1), logical planes 0 and 1 are physical planes 0 and 1 when frame B is 0, and physical planes 2 and 3 when frame B is 1.
- R10: In two-plane display mode, select bits 7:6 and color bits 3:2 are disregarded in color search.
- R11: In color-search mode with no participating plane, rd_data is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_we | input | 1 | Format register write strobe |
| fmt_wdata | input | 10 | Format register value |
| disp_mode | input | 1 | 0 four-plane display, 1 two-plane display |
| rd_req | input | 1 | Processor read request pulse |
| rd_addr | input | AW | Processor read address |
| busy | output | 1 | Read pending |
| rd_valid | output | 1 | One-cycle pulse, rd_data updated |
| rd_data | output | 8 | Formatted read result |
| vram_req | output | 1 | Steal-slot request to the display side |
| vram_addr | output | AW | Memory address of the pending read |
| steal_grant | input | 1 | Slot granted; vram_rdata valid in this cycle |
| vram_rdata | input | 32 | Four plane bytes at vram_addr |

## Verification
The assertions assume that steal_grant is only meaningful while vram_req is high. They also assume that the format register and disp_mode stay fixed while a read is pending, because the result is formed in the grant cycle. The stimulus raises steal_grant only after it has seen vram_req. It changes the format and the display mode only between reads. It never checks a single-plane read whose select field is not one-hot. A stray request is injected in the middle of a pending read, and the check confirms that both the address and the count of result pulses stay the same.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    localparam int NPLANES = 4;
    localparam int PW      = 8;
    localparam int HALF    = NPLANES / 2;
    localparam int FMT_W   = 2 + 2 * NPLANES;

    typedef enum logic {
        DM_FOUR = 1'b0,
        DM_TWO  = 1'b1
    } dmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic               search;
        logic               frame_b;
        logic [NPLANES-1:0] sel;
        logic [NPLANES-1:0] color;
    } fmt_t;

    typedef logic [PW-1:0] pbyte_t;

    // Logical planes a display mode makes reachable.
    function automatic logic [NPLANES-1:0] usable_mask(dmode_e dm);
        logic [NPLANES-1:0] m;
        m = '0;
        for (int i = 0; i < NPLANES; i++) begin
            m[i] = (dm == DM_FOUR) || (i < HALF);
        end
        return m;
    endfunction

endpackage

// File: rtl/vrf_fmt_reg.sv
module vrf_fmt_reg
    import vrf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [FMT_W-1:0] wdata,
    output fmt_t             fmt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt <= '0;
        end else if (we) begin
            fmt <= fmt_t'(wdata);
        end
    end

endmodule

// File: rtl/vrf_steal_ctl.sv
module vrf_steal_ctl #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          grant,
    output logic          busy,
    output logic          capture,
    output logic          valid,
    output logic [AW-1:0] addr
);
    import vrf_pkg::*;

    rd_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            addr  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (rd_req) begin
                        addr  <= rd_addr;
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (grant) begin
                        valid <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state == ST_WAIT);
    assign capture = busy && grant;

endmodule

// File: rtl/vrf_plane_route.sv
module vrf_plane_route
    import vrf_pkg::*;
(
    input  dmode_e                     dm,
    input  logic                       frame_b,
    input  logic [NPLANES*PW-1:0]      raw,
    output logic [NPLANES-1:0][PW-1:0] lp,
    output logic [NPLANES-1:0]         usable
);

    genvar i;
    generate
        for (i = 0; i < NPLANES; i++) begin : g_plane
            if (i < HALF) begin : g_low
                localparam int HI = i + HALF;
                assign lp[i] = (dm == DM_TWO && frame_b) ? raw[HI*PW +: PW]
                                                         : raw[i*PW +: PW];
            end else begin : g_high
                assign lp[i] = (dm == DM_TWO) ? '0 : raw[i*PW +: PW];
            end
        end
    endgenerate

    assign usable = usable_mask(dm);

endmodule

// File: rtl/vrf_fmt_calc.sv
module vrf_fmt_calc
    import vrf_pkg::*;
(
    input  fmt_t                       fmt,
    input  logic [NPLANES-1:0]         usable,
    input  logic [NPLANES-1:0][PW-1:0] lp,
    output pbyte_t                     result
);

    logic [NPLANES-1:0] part;
    pbyte_t             single_v;
    pbyte_t             search_v;

    assign part = fmt.sel & usable;

    // Single-plane: OR of the chosen planes (defined only when one-hot).
    always_comb begin
        single_v = '0;
        for (int i = 0; i < NPLANES; i++) begin
            if (part[i]) single_v = single_v | lp[i];
        end
    end

    genvar k;
    generate
        for (k = 0; k < PW; k++) begin : g_pix
            always_comb begin
                search_v[k] = 1'b1;
                for (int i = 0; i < NPLANES; i++) begin
                    if (part[i] && (lp[i][k] != fmt.color[i])) search_v[k] = 1'b0;
                end
            end
        end
    endgenerate

    assign result = fmt.search ? search_v : single_v;

endmodule

// File: rtl/vrf_read_formatter.sv
module vrf_read_formatter #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fmt_we,
    input  logic [9:0]    fmt_wdata,
    input  logic          disp_mode,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          vram_req,
    output logic [AW-1:0] vram_addr,
    input  logic          steal_grant,
    input  logic [31:0]   vram_rdata
);
    import vrf_pkg::*;

    fmt_t                       fmt;
    logic                       capture;
    logic [NPLANES-1:0][PW-1:0] lp;
    logic [NPLANES-1:0]         usable;
    pbyte_t                     result;
    dmode_e                     dm;

    assign dm = dmode_e'(disp_mode);

    vrf_fmt_reg u_fmt (
        .clk   (clk),
        .rst   (rst),
        .we    (fmt_we),
        .wdata (fmt_wdata),
        .fmt   (fmt)
    );

    vrf_steal_ctl #(.AW(AW)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .grant   (steal_grant),
        .busy    (busy),
        .capture (capture),
        .valid   (rd_valid),
        .addr    (vram_addr)
    );

    vrf_plane_route u_route (
        .dm      (dm),
        .frame_b (fmt.frame_b),
        .raw     (vram_rdata),
        .lp      (lp),
        .usable  (usable)
    );

    vrf_fmt_calc u_calc (
        .fmt    (fmt),
        .usable (usable),
        .lp     (lp),
        .result (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (capture) begin
            rd_data <= result;
        end
    end

    assign vram_req = busy;

endmodule

// File: rtl/vrf_read_formatter_chk.sv
module vrf_read_formatter_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_req,
    input logic          steal_grant,
    input logic          busy,
    input logic          rd_valid,
    input logic          vram_req,
    input logic [AW-1:0] vram_addr,
    input logic [7:0]    rd_data
);

    a_r2_busy_after_req: assert property (@(posedge clk) disable iff (rst)
        (!busy && rd_req) |=> busy);

    a_r2_req_is_busy: assert property (@(posedge clk) disable iff (rst)
        vram_req == busy);

    a_r3_valid_after_grant: assert property (@(posedge clk) disable iff (rst)
        (busy && steal_grant) |=> (rd_valid && !busy));

    a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r3_data_held: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> $stable(rd_data));

    a_r4_addr_held: assert property (@(posedge clk) disable iff (rst)
        (busy && !steal_grant) |=> (busy && $stable(vram_addr)));

    a_r1_valid_not_busy: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !busy);

endmodule

bind vrf_read_formatter vrf_read_formatter_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_req      (rd_req),
    .steal_grant (steal_grant),
    .busy        (busy),
    .rd_valid    (rd_valid),
    .vram_req    (vram_req),
    .vram_addr   (vram_addr),
    .rd_data     (rd_data)
);

// File: tb/vrf_read_formatter_bench.sv
`timescale 1ns/1ps
module vrf_read_formatter_bench;

    typedef struct {
        logic [7:0] v;
        int         r;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_we = 1'b0;
    logic [9:0]  fmt_wdata = '0;
    logic        disp_mode = 1'b0;
    logic        rd_req = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        busy, rd_valid, vram_req;
    logic [7:0]  rd_data;
    logic [15:0] vram_addr;
    logic        steal_grant = 1'b0;
    logic [31:0] vram_rdata;

    int checks = 0;
    int errors = 0;
    int nvalid = 0;
    int nreads = 0;
    bit done   = 1'b0;
    exp_t sb[$];

    logic       c_search, c_frame;
    logic [3:0] c_sel, c_color;

    always #2.5 clk = ~clk;

    vrf_read_formatter #(.AW(16)) u_vrf_read_formatter (
        .clk(clk), .rst(rst), .fmt_we(fmt_we), .fmt_wdata(fmt_wdata),
        .disp_mode(disp_mode), .rd_req(rd_req), .rd_addr(rd_addr),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .vram_req(vram_req), .vram_addr(vram_addr),
        .steal_grant(steal_grant), .vram_rdata(vram_rdata)
    );

    function automatic logic [7:0] pb(int p, logic [15:0] a);
        return 8'((int'(a) * 29) + (p * 71)) ^ 8'(a >> 2);
    endfunction

    for (genvar p = 0; p < 4; p++) begin : g_mem
        assign vram_rdata[p*8 +: 8] = pb(p, vram_addr);
    end

    // Expected byte from R5..R11.
    function automatic logic [7:0] expect_byte(logic [15:0] a);
        logic [7:0] r;
        r = c_search ? 8'hFF : 8'h00;
        for (int i = 0; i < 4; i++) begin
            bit use_i;
            int ph;
            logic [7:0] d;
            use_i = c_sel[i] && (!disp_mode || i < 2);
            ph    = (disp_mode && c_frame) ? i + 2 : i;
            d     = pb(ph, a);
            if (use_i) begin
                if (!c_search) r = r | d;
                else for (int k = 0; k < 8; k++) if (d[k] != c_color[i]) r[k] = 1'b0;
            end
        end
        return r;
    endfunction

    task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic set_fmt(input logic s, input logic f, input logic [3:0] sel, input logic [3:0] col);
        c_search = s; c_frame = f; c_sel = sel; c_color = col;
        fmt_wdata = {s, f, sel, col};
        fmt_we = 1'b1;
        @(negedge clk);
        fmt_we = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input int gap, input int r, input bit poke);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        chk(2, busy, 1);           // R2
        chk(2, vram_req, 1);
        chk(2, vram_addr, a);
        for (int g = 0; g < gap; g++) begin
            if (poke && g == 0) begin rd_req = 1'b1; rd_addr = ~a; end
            @(negedge clk);
            rd_req = 1'b0;
        end
        if (poke) chk(4, vram_addr, a);   // R4
        sb.push_back('{v: expect_byte(a), r: r});
        nreads++;
        steal_grant = 1'b1;
        @(negedge clk);
        steal_grant = 1'b0;
        chk(3, rd_valid, 1);       // R3
        chk(3, busy, 0);
        @(negedge clk);
        chk(3, rd_valid, 0);
    endtask

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            nvalid++;
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4 actual=unexpected rd_valid expected=none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.r, rd_data, e.v);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        c_search = 0; c_frame = 0; c_sel = 0; c_color = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(1, busy, 0); chk(1, rd_valid, 0); chk(1, vram_req, 0); chk(1, rd_data, 0);

        // R5, R6: single plane, four-plane display
        disp_mode = 1'b0;
        for (int p = 0; p < 4; p++) begin
            set_fmt(0, 0, 4'b0001 << p, 4'h0);
            do_read(16'h0100 + 16'(p * 13), p, 6, 0);
        end
        // R7: frame bit no effect in four-plane mode
        set_fmt(0, 1, 4'b0010, 4'h0);
        do_read(16'h0222, 1, 7, 0);
        set_fmt(0, 1, 4'b1000, 4'h0);
        do_read(16'h0345, 0, 7, 0);

        // R8: color search four-plane, several colors and subsets
        for (int c = 0; c < 16; c += 5) begin
            set_fmt(1, 0, 4'b1111, 4'(c));
            do_read(16'h1000 + 16'(c * 7), 2, 8, 0);
        end
        set_fmt(1, 0, 4'b0101, 4'b0100);
        do_read(16'h2468, 1, 8, 0);
        set_fmt(1, 1, 4'b1010, 4'b1000);
        do_read(16'h1357, 0, 8, 0);

        // R11: no participating plane
        set_fmt(1, 0, 4'b0000, 4'b1010);
        do_read(16'h0777, 1, 11, 0);

        // R9: two-plane display, frame picks the pair
        disp_mode = 1'b1;
        set_fmt(0, 0, 4'b0001, 4'h0); do_read(16'h0400, 1, 9, 0);
        set_fmt(0, 0, 4'b0010, 4'h0); do_read(16'h0401, 1, 9, 0);
        set_fmt(0, 1, 4'b0001, 4'h0); do_read(16'h0402, 1, 9, 0);
        set_fmt(0, 1, 4'b0010, 4'h0); do_read(16'h0403, 1, 9, 0);

        // R10: upper select and color bits disregarded in two-plane search
        set_fmt(1, 1, 4'b1111, 4'b1101); do_read(16'h0505, 2, 10, 0);
        set_fmt(1, 0, 4'b1111, 4'b0110); do_read(16'h0606, 2, 10, 0);
        set_fmt(1, 0, 4'b1100, 4'b1111); do_read(16'h0707, 1, 10, 0);  // R11 too

        // R4: stray request while busy
        disp_mode = 1'b0;
        set_fmt(0, 0, 4'b0100, 4'h0);
        do_read(16'h0A0A, 4, 4, 1);
        // R3: immediate grant, data held afterwards
        do_read(16'h0B0B, 0, 3, 0);
        held = pb(2, 16'h0B0B);
        repeat (4) @(negedge clk);
        chk(3, rd_data, held);
        // R5: format write takes effect on the next read
        set_fmt(0, 0, 4'b0001, 4'h0);
        do_read(16'h0B0B, 1, 5, 0);

        repeat (3) @(negedge clk);
        chk(4, nvalid, nreads);   // R4: no extra result pulses
        chk(4, sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule